// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-facing half of a serial non-volatile memory. It watches a two-wire bus (clock and data, both sampled into the system clock domain), recognises bus start and stop conditions, and decodes a control byte made of a fixed device code, select bits and a direction bit. It answers by pulling the data line low through an open-drain enable. Part of the select field is compared with a strap input. The remaining select bits choose one of several memory segments and form the top of the byte address.

For writes, the engine loads a word address and then streams data bytes into an external page buffer. The column bits of the address advance and wrap within a 16-byte page. A stop condition after at least one accepted data byte fires a single strobe that starts the external self-timed programming cycle. While that cycle runs (busy input high), control bytes are not acknowledged, so a master can poll for completion. For reads, bytes come from an external array port at the current pointer. The pointer then advances linearly over the whole space. A master acknowledge asks for the next byte, and a missing acknowledge makes the engine let go of the line.

Top module: `twi_eeprom_slave`

## Requirements
- R1: Out of reset, sda_oe_o, pb_wr_o and prog_start_o are low. A START condition (data falling while clock is high) restarts control-byte reception from any state. A STOP condition (data rising while clock is high) ends the transaction.
- R2: The control byte is received MSB first. The engine acknowledges it (sda_oe_o high through the ninth clock) only if bits 7:4 equal 1010 and bit 3 equals chip_sel_i. On a mismatch it stays silent and ignores the bus until the next START.
- R3: Bits 2:1 of an acknowledged control byte become address bits 9:8. In a write, the next byte becomes address bits 7:0. A read control byte sets only bits 9:8 and keeps the lower bits.
- R4: While busy_i is high, no control byte is acknowledged, even one that matches.
- R5: In a write, every data byte after the word address is acknowledged. Each byte is handed out as a one-cycle pb_wr_o with pb_addr_o and pb_data_o. After each byte, address bits 3:0 increment and wrap inside the page, and bits 9:4 hold.
- R6: A STOP that follows at least one accepted data byte gives exactly one prog_start_o pulse. A STOP with no data byte, or a transaction aborted by a START, gives none.
- R7: With wp_i high, the control and word-address bytes are still acknowledged. The first data byte is not acknowledged, no pb_wr_o is issued, and the following STOP starts no programming.
- R8: In a read, bytes of rd_data_i at rd_addr_o are sent MSB first, and the line is released for the master's acknowledge bit. After each byte the 10-bit pointer increments by one and wraps from 1023 to 0. A master ACK gets the next byte. A NACK leaves sda_oe_o low until the next START.
- R9: sda_oe_o only becomes active while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data line low |
| chip_sel_i | input | 1 | Strap compared with control-byte bit 3 |
| wp_i | input | 1 | Write protect, 1 blocks programming |
| busy_i | input | 1 | Internal programming cycle in progress |
| rd_addr_o | output | 10 | Array read address (current pointer) |
| rd_req_o | output | 1 | One-cycle strobe when a read byte is taken |
| rd_data_i | input | 8 | Array data at rd_addr_o, valid one cycle after the address |
| pb_wr_o | output | 1 | One-cycle page-buffer write strobe |
| pb_addr_o | output | 10 | Page-buffer write address |
| pb_data_o | output | 8 | Page-buffer write data |
| prog_start_o | output | 1 | One-cycle pulse that starts the programming cycle |

## Verification
The hardest situations to reach are the ones where the engine must hold back an acknowledge on a byte that is otherwise well formed: a matching control byte while a programming cycle is running, and the first data byte under write protect. The bench reaches them by driving busy_i and wp_i itself around complete bus transfers. It then confirms at the ports that no page-buffer strobe and no programming pulse follow. Pointer wrap in both forms is reached with repeated START: a write header sets the address near a page end or at 1023, and then either a page write or a read continues across the boundary.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    RX_CTRL,
    RX_WADDR,
    RX_DATA
  } rx_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int NUM    = 2,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] raw_i,
  output logic [NUM-1:0] lvl_o,
  output logic [NUM-1:0] prv_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;   // idle bus is high
      else         chain_q <= {chain_q[STAGES-1:0], raw_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
    assign prv_o[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic scl_lvl_i,
  input  logic scl_prv_i,
  input  logic sda_lvl_i,
  input  logic sda_prv_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_high;
  assign scl_high   = scl_lvl_i & scl_prv_i;
  assign start_o    = scl_high & sda_prv_i & ~sda_lvl_i;
  assign stop_o     = scl_high & ~sda_prv_i & sda_lvl_i;
  assign scl_rise_o = scl_lvl_i & ~scl_prv_i;
  assign scl_fall_o = ~scl_lvl_i & scl_prv_i;
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int AW   = 10,
  parameter int PW   = 4,
  parameter int SEGW = 2,
  localparam int WW  = AW - SEGW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_seg_i,
  input  logic [SEGW-1:0] seg_i,
  input  logic            ld_word_i,
  input  logic [WW-1:0]   word_i,
  input  logic            inc_page_i,
  input  logic            inc_lin_i,
  output logic [AW-1:0]   ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (ld_seg_i)   ptr_q[AW-1 -: SEGW] <= seg_i;
    else if (ld_word_i)  ptr_q[WW-1:0] <= word_i;
    else if (inc_page_i) ptr_q[PW-1:0] <= ptr_q[PW-1:0] + 1'b1;
    else if (inc_lin_i)  ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_page_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_page_i |=> (ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])) &&
                   (ptr_q[PW-1:0] == $past(ptr_q[PW-1:0]) + 1'b1));

  assert_linear_inc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_lin_i && !inc_page_i && !ld_seg_i && !ld_word_i) |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 4,
  localparam int SEGW = AW - 8,
  localparam int CSW  = 3 - SEGW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe_o,
  input  logic [CSW-1:0] chip_sel_i,
  input  logic           wp_i,
  input  logic           busy_i,
  output logic [AW-1:0]  rd_addr_o,
  output logic           rd_req_o,
  input  logic [7:0]     rd_data_i,
  output logic           pb_wr_o,
  output logic [AW-1:0]  pb_addr_o,
  output logic [7:0]     pb_data_o,
  output logic           prog_start_o
);
  logic [1:0] lvl, prv;
  logic scl_lvl, sda_lvl;
  logic start, stop, scl_rise, scl_fall;

  twi_sync #(.NUM(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({sda_i, scl_i}),
    .lvl_o (lvl),
    .prv_o (prv)
  );

  assign scl_lvl = lvl[0];
  assign sda_lvl = lvl[1];

  twi_cond_detect u_cond (
    .scl_lvl_i (lvl[0]),
    .scl_prv_i (prv[0]),
    .sda_lvl_i (lvl[1]),
    .sda_prv_i (prv[1]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  st_e        st_q;
  rx_e        rx_kind_q, nxt_rx_q;
  logic [2:0] cnt_q;
  logic       byte_full_q;
  logic [7:0] rx_sh_q, tx_sh_q;
  logic       sda_oe_q, go_tx_q, wr_pend_q, macked_q, ack_ctrl_q;
  logic       pb_wr_q, prog_q, rd_req_q;
  logic [AW-1:0] pb_addr_q;
  logic [7:0] pb_data_q;
  logic [AW-1:0] ptr;

  logic quiet, rx_done, dev_ok, ctrl_ack;
  logic ld_seg, ld_word, inc_page, tx_load;

  always_comb begin
    quiet    = !start && !stop;
    rx_done  = quiet && (st_q == ST_RX) && byte_full_q && scl_fall;
    dev_ok   = (rx_sh_q[7:4] == DEV_CODE) && (rx_sh_q[3 -: CSW] == chip_sel_i);
    ctrl_ack = dev_ok && !busy_i;
    ld_seg   = rx_done && (rx_kind_q == RX_CTRL) && ctrl_ack;
    ld_word  = rx_done && (rx_kind_q == RX_WADDR);
    inc_page = rx_done && (rx_kind_q == RX_DATA) && !wp_i;
    tx_load  = quiet && scl_fall &&
               (((st_q == ST_ACK) && go_tx_q) || ((st_q == ST_MACK) && macked_q));
  end

  twi_addr_ptr #(.AW(AW), .PW(PW), .SEGW(SEGW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_seg_i  (ld_seg),
    .seg_i     (rx_sh_q[SEGW:1]),
    .ld_word_i (ld_word),
    .word_i    (rx_sh_q),
    .inc_page_i(inc_page),
    .inc_lin_i (tx_load),
    .ptr_o     (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rx_kind_q   <= RX_CTRL;
      nxt_rx_q    <= RX_CTRL;
      cnt_q       <= '0;
      byte_full_q <= 1'b0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      sda_oe_q    <= 1'b0;
      go_tx_q     <= 1'b0;
      wr_pend_q   <= 1'b0;
      macked_q    <= 1'b0;
      ack_ctrl_q  <= 1'b0;
      pb_wr_q     <= 1'b0;
      pb_addr_q   <= '0;
      pb_data_q   <= '0;
      prog_q      <= 1'b0;
      rd_req_q    <= 1'b0;
    end else begin
      pb_wr_q  <= 1'b0;
      prog_q   <= 1'b0;
      rd_req_q <= 1'b0;
      if (start) begin
        st_q        <= ST_RX;
        rx_kind_q   <= RX_CTRL;
        cnt_q       <= '0;
        byte_full_q <= 1'b0;
        sda_oe_q    <= 1'b0;
        wr_pend_q   <= 1'b0;
        ack_ctrl_q  <= 1'b0;
      end else if (stop) begin
        st_q       <= ST_IDLE;
        sda_oe_q   <= 1'b0;
        prog_q     <= wr_pend_q;
        wr_pend_q  <= 1'b0;
        ack_ctrl_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && !byte_full_q) begin
              rx_sh_q <= {rx_sh_q[6:0], sda_lvl};
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == 3'd7) byte_full_q <= 1'b1;
            end else if (rx_done) begin
              byte_full_q <= 1'b0;
              cnt_q       <= '0;
              unique case (rx_kind_q)
                RX_CTRL: begin
                  if (ctrl_ack) begin
                    sda_oe_q   <= 1'b1;
                    st_q       <= ST_ACK;
                    ack_ctrl_q <= 1'b1;
                    go_tx_q    <= rx_sh_q[0];
                    nxt_rx_q   <= RX_WADDR;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                RX_WADDR: begin
                  sda_oe_q <= 1'b1;
                  st_q     <= ST_ACK;
                  go_tx_q  <= 1'b0;
                  nxt_rx_q <= RX_DATA;
                end
                default: begin
                  if (!wp_i) begin
                    sda_oe_q  <= 1'b1;
                    st_q      <= ST_ACK;
                    go_tx_q   <= 1'b0;
                    nxt_rx_q  <= RX_DATA;
                    wr_pend_q <= 1'b1;
                    pb_wr_q   <= 1'b1;
                    pb_addr_q <= ptr;
                    pb_data_q <= rx_sh_q;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              ack_ctrl_q <= 1'b0;
              if (!go_tx_q) begin
                sda_oe_q  <= 1'b0;
                st_q      <= ST_RX;
                rx_kind_q <= nxt_rx_q;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == 3'd7) begin
                sda_oe_q <= 1'b0;   // hand the line to the master for its ack bit
                st_q     <= ST_MACK;
              end else begin
                cnt_q    <= cnt_q + 1'b1;
                tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
                sda_oe_q <= ~tx_sh_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) macked_q <= ~sda_lvl;
            else if (scl_fall && !macked_q) st_q <= ST_IDLE;
          end
          default: ;
        endcase
        if (tx_load) begin
          st_q     <= ST_TX;
          tx_sh_q  <= rd_data_i;
          sda_oe_q <= ~rd_data_i[7];
          cnt_q    <= '0;
          rd_req_q <= 1'b1;
          macked_q <= 1'b0;
        end
      end
    end
  end

  assign sda_oe_o     = sda_oe_q;
  assign rd_addr_o    = ptr;
  assign rd_req_o     = rd_req_q;
  assign pb_wr_o      = pb_wr_q;
  assign pb_addr_o    = pb_addr_q;
  assign pb_data_o    = pb_data_q;
  assign prog_start_o = prog_q;

  assert_drive_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_lvl);

  assert_ctrl_ack_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_q) && ack_ctrl_q) |-> !$past(busy_i));

  assert_ctrl_ack_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_q) && ack_ctrl_q) |-> ($past(rx_sh_q[7:4]) == DEV_CODE));

  assert_prog_on_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(stop));

  assert_no_pb_wp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_wr_o |-> !$past(wp_i));

  assert_prog_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);
endmodule

// File: tb/test_twi_eeprom_slave.sv
module test_twi_eeprom_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 10;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic chip_sel = 1'b0, wp = 1'b0, busy = 1'b0;
  logic sda_oe, sda_bus;
  logic [AW-1:0] rd_addr, pb_addr;
  logic rd_req, pb_wr, prog;
  logic [7:0] rd_data, pb_data;
  logic [7:0] mem [1024];

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = mem[rd_addr];

  int checks = 0, errors = 0, prog_cnt = 0, r9_viol = 0;
  bit finished = 1'b0;
  logic [AW+7:0] exp_q[$];
  logic [AW+7:0] mon_e;
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  twi_eeprom_slave i_twi_eeprom_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .chip_sel_i  (chip_sel),
    .wp_i        (wp),
    .busy_i      (busy),
    .rd_addr_o   (rd_addr),
    .rd_req_o    (rd_req),
    .rd_data_i   (rd_data),
    .pb_wr_o     (pb_wr),
    .pb_addr_o   (pb_addr),
    .pb_data_o   (pb_data),
    .prog_start_o(prog)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + (a >> 4) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus};
      tick(Q);
      scl_m = 1'b0;
    end
    sda_m = !mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic expect_pb(input int a, input logic [7:0] d);
    exp_q.push_back({AW'(a), d});
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor for page-buffer writes, program strobes and R9
  always @(negedge clk) begin
    if (rst_n) begin
      if (pb_wr) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R5 R7 unexpected page write actual=%0h expected=none", {pb_addr, pb_data});
        end else begin
          mon_e = exp_q.pop_front();
          if ({pb_addr, pb_data} !== mon_e) begin
            errors++;
            $display("FAIL R5 page write actual=%0h expected=%0h", {pb_addr, pb_data}, mon_e);
          end
        end
      end
      if (prog) prog_cnt++;
      if (sda_oe && !oe_prev && scl_m && scl_prev) r9_viol++;
    end
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    tick(5);
    chk(sda_oe == 1'b0 && pb_wr == 1'b0 && prog == 1'b0, "R1 reset outputs", {sda_oe, pb_wr, prog}, 0);
    rst_n = 1'b1;
    tick(5);

    // byte write
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R2 control ack", ack, 1);
    send_byte(8'h35, ack); chk(ack, "R3 word address ack", ack, 1);
    expect_pb(10'h035, 8'h5A);
    send_byte(8'h5A, ack); chk(ack, "R5 data ack", ack, 1);
    bus_stop(); tick(5);
    chk(prog_cnt == 1, "R6 program after stop", prog_cnt, 1);

    // busy polling
    busy = 1'b1;
    bus_start();
    send_byte(8'hA0, ack); chk(!ack, "R4 no ack while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R4 ack after busy clears", ack, 1);
    bus_stop(); tick(5);
    chk(prog_cnt == 1, "R6 no program without data", prog_cnt, 1);

    // mismatches
    bus_start();
    send_byte(8'hB0, ack); chk(!ack, "R2 wrong device code", ack, 0);
    send_byte(8'hA0, ack); chk(!ack, "R2 ignored until START", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA8, ack); chk(!ack, "R2 wrong chip select", ack, 0);
    bus_stop();
    chip_sel = 1'b1;
    bus_start();
    send_byte(8'hA8, ack); chk(ack, "R2 chip select high", ack, 1);
    bus_stop();
    chip_sel = 1'b0;

    // page write with segment and page wrap
    bus_start();
    send_byte(8'hA6, ack); chk(ack, "R3 segment control ack", ack, 1);
    send_byte(8'hFE, ack);
    expect_pb(10'h3FE, 8'h11);
    expect_pb(10'h3FF, 8'h22);
    expect_pb(10'h3F0, 8'h33);
    expect_pb(10'h3F1, 8'h44);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    send_byte(8'h44, ack); chk(ack, "R5 fourth page byte ack", ack, 1);
    bus_stop(); tick(5);
    chk(prog_cnt == 2, "R6 program after page write", prog_cnt, 2);

    // abort by repeated START
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h10, ack);
    expect_pb(10'h010, 8'h77);
    send_byte(8'h77, ack);
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R1 restart control ack", ack, 1);
    bus_stop(); tick(5);
    chk(prog_cnt == 2, "R6 START aborts program", prog_cnt, 2);

    // write protect
    wp = 1'b1;
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R7 control ack under protect", ack, 1);
    send_byte(8'h20, ack); chk(ack, "R7 address ack under protect", ack, 1);
    send_byte(8'h99, ack); chk(!ack, "R7 data refused under protect", ack, 0);
    bus_stop(); tick(5);
    chk(prog_cnt == 2, "R7 no program under protect", prog_cnt, 2);
    wp = 1'b0;

    // random read across segment boundary
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hA3, ack); chk(ack, "R8 read control ack", ack, 1);
    recv_byte(1'b1, rb); chk(rb == pat(10'h1FE), "R8 read 1FE", rb, pat(10'h1FE));
    recv_byte(1'b1, rb); chk(rb == pat(10'h1FF), "R8 read 1FF", rb, pat(10'h1FF));
    recv_byte(1'b0, rb); chk(rb == pat(10'h200), "R8 read 200", rb, pat(10'h200));
    tick(3 * Q);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    bus_stop();

    // full-space wrap
    bus_start();
    send_byte(8'hA6, ack);
    send_byte(8'hFF, ack);
    bus_start();
    send_byte(8'hA7, ack);
    recv_byte(1'b1, rb); chk(rb == pat(10'h3FF), "R8 read 3FF", rb, pat(10'h3FF));
    recv_byte(1'b0, rb); chk(rb == pat(0), "R8 wrap to 000", rb, pat(0));
    bus_stop();

    // current-address read keeps lower bits, takes segment from control
    bus_start();
    send_byte(8'hA1, ack); chk(ack, "R3 current read ack", ack, 1);
    recv_byte(1'b0, rb); chk(rb == pat(1), "R3 current address 001", rb, pat(1));
    bus_stop();
    tick(10);

    chk(exp_q.size() == 0, "R5 all page writes seen", exp_q.size(), 0);
    chk(r9_viol == 0, "R9 drive only while SCL low", r9_viol, 0);
    report();
  end
endmodule